// File: doc/BRIEF.md
# Autonomous ADC Step Sequencer

This block drives an external analog-to-digital converter through a programmed list of conversion steps. No processor service is needed between samples. Software loads a small step table. Each entry selects one of eight analog inputs, picks single-ended or differential mode, asks for an interrupt when that sample is done, and can mark the end of the list. When a trigger pulse arrives, the controller starts at entry 0. For each step it issues a one-cycle conversion request with the step's channel and mode, then waits for the converter's done strobe. It stores the 12-bit result in a result FIFO and moves on to the next entry.

Software reads results one at a time from a data register, in the order they were captured. A level register reports the FIFO occupancy together with empty and full flags. A status register holds a busy flag and three sticky bits: interrupt pending, FIFO overflow and trigger overrun. Writing a one to a sticky bit clears it. The interrupt output follows the pending bit. The table length and the FIFO depth are parameters.

Top module: `adc_sequencer`

## Requirements
- R1: After reset the controller is idle and `conv_req` and `irq` are low. The status register reads 0, and the level register shows count 0, empty 1 and full 0.
- R2: A one-cycle pulse on `trig` while idle starts the table at entry 0 and walks the entries in index order. Each step gets exactly one single-cycle `conv_req`. The next request is issued only after `conv_done` for the previous step. A step word (written at address 16+i for entry i) holds the channel in bits 2:0, the differential flag in bit 3, the interrupt flag in bit 4 and the end flag in bit 5. While a step is being converted, `conv_chan` and `conv_diff` carry its bits 2:0 and bit 3.
- R3: The sequence stops after completing the first step whose end flag (bit 5) is set.
- R4: If no step up to the last table entry has its end flag set, the sequence stops after entry STEPS-1.
- R5: Each result is pushed into the FIFO. Reads of the data register (address 1) return results oldest first, each 12-bit value unchanged, so full-scale 4095 reads as 4095. Each such read removes one entry.
- R6: The level register (address 2) shows the occupancy count in its low bits, the empty flag in bit 14 and the full flag in bit 15.
- R7: A result that arrives while the FIFO is full is discarded and sets sticky overflow (status bit 2). The sequence still advances through its remaining steps.
- R8: When a step with its interrupt flag set completes, interrupt pending (status bit 1) is set. `irq` follows that bit and stays high until a status write with bit 1 set. Status writes with bit 1 clear leave it unchanged.
- R9: A trigger that arrives while a sequence is running is ignored: no extra steps are run. It sets sticky trigger overrun (status bit 3), which a status write with bit 3 set clears.
- R10: Status bit 0 reads 1 while a sequence is running and 0 when the controller is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig | input | 1 | Sequence start pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops FIFO on data address) |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel of the current step |
| conv_diff | output | 1 | Differential mode of the current step |
| conv_done | input | 1 | Converter done strobe |
| conv_result | input | 12 | Converter result, valid with `conv_done` |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a result that arrives while the FIFO is full. The bench first runs a table with no end flag, so exactly a FIFO depth of results is stored, and leaves them unread. It then starts a short second sequence and checks that the stored data is untouched and that every step was still requested. Trigger overrun needs a trigger that lands mid-sequence. The bench's converter model has an adjustable latency, which is stretched so that a second trigger and a busy-flag read both fall inside a running sequence.

// File: rtl/adcseq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the step-word layout for the ADC sequencer.
// Assumes eight analog inputs and a 12-bit converter.
package adcseq_pkg;
    localparam int CH_W   = 3;
    localparam int RES_W  = 12;
    localparam int REG_W  = 16;
    localparam int ADDR_W = 5;

    // Step word: bit5 end, bit4 interrupt, bit3 differential, bits2:0 channel
    typedef struct packed {
        logic            last;
        logic            irq_en;
        logic            diff;
        logic [CH_W-1:0] chan;
    } step_t;

    localparam int STEP_W = $bits(step_t);

    localparam logic [ADDR_W-1:0] A_STATUS = 5'd0;
    localparam logic [ADDR_W-1:0] A_DATA   = 5'd1;
    localparam logic [ADDR_W-1:0] A_LEVEL  = 5'd2;

    localparam int ST_BUSY = 0;
    localparam int ST_IRQ  = 1;
    localparam int ST_OVF  = 2;
    localparam int ST_TRG  = 3;
endpackage

// File: rtl/seq_step_table.sv
`timescale 1ns/1ps
// Step table: STEPS registered step words, one write port and two read ports
// (one for the sequencer, one for register read-back). Assumes STEPS >= 2.
module seq_step_table
    import adcseq_pkg::*;
#(
    parameter int STEPS = 8,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  step_t            wr_step,
    input  logic [IDX_W-1:0] seq_idx,
    output step_t            seq_step,
    input  logic [IDX_W-1:0] rd_idx,
    output step_t            rd_step
);
    step_t ent [STEPS];

    for (genvar g = 0; g < STEPS; g++) begin : g_ent
        step_t ent_q;
        // Hold one table entry, loaded by a matching register write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ent_q <= '0;
            else if (wr_en && wr_idx == IDX_W'(g))
                ent_q <= wr_step;
        end
        assign ent[g] = ent_q;
    end

    assign seq_step = ent[seq_idx];
    assign rd_step  = ent[rd_idx];
endmodule

// File: rtl/seq_result_fifo.sv
`timescale 1ns/1ps
// Result FIFO: circular buffer with occupancy count and empty/full flags.
// A push while full and a pop while empty are ignored. Assumes DEPTH >= 2.
module seq_result_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 12,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic [CNT_W-1:0] count,
    output logic             empty,
    output logic             full
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_wr, do_rd;

    assign empty = (count == '0);
    assign full  = (count == CNT_W'(DEPTH));
    assign do_wr = push && !full;
    assign do_rd = pop && !empty;
    assign dout  = mem[rp];

    // Store an accepted result at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wp] <= din;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_wr)
                wp <= (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_rd)
                rp <= (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_wr && !do_rd)
                count <= count + 1'b1;
            else if (do_rd && !do_wr)
                count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/seq_ctrl.sv
`timescale 1ns/1ps
// Sequencer FSM: walks the step table on a trigger, issues one conversion
// request per step, waits for done, pushes the result and keeps the sticky
// status bits (interrupt, overflow, trigger overrun). Set wins over clear.
module seq_ctrl
    import adcseq_pkg::*;
#(
    parameter int STEPS = 8,
    localparam int IDX_W = $clog2(STEPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  step_t            step,
    output logic [IDX_W-1:0] idx,
    output logic             conv_req,
    input  logic             conv_done,
    input  logic             fifo_full,
    output logic             push,
    input  logic             clr_irq,
    input  logic             clr_ovf,
    input  logic             clr_trg,
    output logic             busy,
    output logic             irq_pend,
    output logic             ovf,
    output logic             trg_ovr
);
    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
    state_t state;
    logic   done_now, final_step;

    assign done_now   = (state == S_WAIT) && conv_done;
    assign final_step = step.last || (idx == IDX_W'(STEPS - 1));
    assign conv_req   = (state == S_REQ);
    assign busy       = (state != S_IDLE);
    assign push       = done_now && !fifo_full;

    // Step through the table: idle -> request -> wait for done -> next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                S_IDLE: if (trig) begin
                    idx   <= '0;
                    state <= S_REQ;
                end
                S_REQ: state <= S_WAIT;
                S_WAIT: if (conv_done) begin
                    if (final_step) begin
                        state <= S_IDLE;
                    end else begin
                        idx   <= idx + 1'b1;
                        state <= S_REQ;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Sticky status bits, cleared by write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pend <= 1'b0;
            ovf      <= 1'b0;
            trg_ovr  <= 1'b0;
        end else begin
            irq_pend <= (done_now && step.irq_en) || (irq_pend && !clr_irq);
            ovf      <= (done_now && fifo_full)   || (ovf && !clr_ovf);
            trg_ovr  <= (trig && busy)            || (trg_ovr && !clr_trg);
        end
    end
endmodule

// File: rtl/adc_sequencer.sv
`timescale 1ns/1ps
// Top: ADC step sequencer. Decodes the register interface (status, FIFO data,
// FIFO level, step table at 16+i) and connects table, FSM and result FIFO.
// Assumes STEPS <= 16 and a converter that answers each request with one
// done strobe no earlier than the cycle after the request.
module adc_sequencer
    import adcseq_pkg::*;
#(
    parameter int STEPS = 8,
    parameter int DEPTH = 8,
    localparam int IDX_W = $clog2(STEPS),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    output logic              conv_diff,
    input  logic              conv_done,
    input  logic [RES_W-1:0]  conv_result,
    output logic              irq
);
    logic             step_hit, step_wr, pop;
    logic [IDX_W-1:0] seq_idx;
    step_t            seq_step, rd_step;
    logic             push, busy, irq_pend, ovf, trg_ovr;
    logic             clr_irq, clr_ovf, clr_trg;
    logic [RES_W-1:0] fifo_dout;
    logic [CNT_W-1:0] fifo_count;
    logic             fifo_empty, fifo_full;
    logic             wdata_unused;

    assign wdata_unused = ^reg_wdata[REG_W-1:STEP_W];

    // Address decode for table writes, FIFO pops and status clears.
    assign step_hit = reg_addr[4] && (int'(reg_addr[3:0]) < STEPS);
    assign step_wr  = reg_wr && step_hit;
    assign pop      = reg_rd && (reg_addr == A_DATA) && !fifo_empty;
    assign clr_irq  = reg_wr && (reg_addr == A_STATUS) && reg_wdata[ST_IRQ];
    assign clr_ovf  = reg_wr && (reg_addr == A_STATUS) && reg_wdata[ST_OVF];
    assign clr_trg  = reg_wr && (reg_addr == A_STATUS) && reg_wdata[ST_TRG];

    seq_step_table #(.STEPS(STEPS)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (step_wr),
        .wr_idx   (reg_addr[IDX_W-1:0]),
        .wr_step  (step_t'(reg_wdata[STEP_W-1:0])),
        .seq_idx  (seq_idx),
        .seq_step (seq_step),
        .rd_idx   (reg_addr[IDX_W-1:0]),
        .rd_step  (rd_step)
    );

    seq_ctrl #(.STEPS(STEPS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .step      (seq_step),
        .idx       (seq_idx),
        .conv_req  (conv_req),
        .conv_done (conv_done),
        .fifo_full (fifo_full),
        .push      (push),
        .clr_irq   (clr_irq),
        .clr_ovf   (clr_ovf),
        .clr_trg   (clr_trg),
        .busy      (busy),
        .irq_pend  (irq_pend),
        .ovf       (ovf),
        .trg_ovr   (trg_ovr)
    );

    seq_result_fifo #(.DEPTH(DEPTH), .W(RES_W)) fifo_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   (conv_result),
        .pop   (pop),
        .dout  (fifo_dout),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    assign conv_chan = seq_step.chan;
    assign conv_diff = seq_step.diff;
    assign irq       = irq_pend;

    // Read-data multiplexer.
    always_comb begin
        reg_rdata = '0;
        if (step_hit) begin
            reg_rdata[STEP_W-1:0] = rd_step;
        end else begin
            case (reg_addr)
                A_STATUS: begin
                    reg_rdata[ST_BUSY] = busy;
                    reg_rdata[ST_IRQ]  = irq_pend;
                    reg_rdata[ST_OVF]  = ovf;
                    reg_rdata[ST_TRG]  = trg_ovr;
                end
                A_DATA:  if (!fifo_empty) reg_rdata[RES_W-1:0] = fifo_dout;
                A_LEVEL: begin
                    reg_rdata[CNT_W-1:0] = fifo_count;
                    reg_rdata[14]        = fifo_empty;
                    reg_rdata[15]        = fifo_full;
                end
                default: reg_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/seq_checker.sv
`timescale 1ns/1ps
// Checker: temporal properties of the sequencer, bound to adc_sequencer.
module seq_checker
    import adcseq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trig,
    input logic              conv_req,
    input logic              irq,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [REG_W-1:0]  reg_wdata,
    input logic              busy,
    input logic              ovf,
    input logic              trg_ovr,
    input logic              fifo_full,
    input logic [CNT_W-1:0]  fifo_count
);
    logic st_wr;
    assign st_wr = reg_wr && (reg_addr == A_STATUS);

    a_r2_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);
    a_r10_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> busy);
    a_r8_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(st_wr && reg_wdata[ST_IRQ])) |=> irq);
    a_r9_trg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (trg_ovr && !(st_wr && reg_wdata[ST_TRG])) |=> trg_ovr);
    a_r9_trig_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy) |=> trg_ovr);
    a_r7_ovf_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf) |-> $past(fifo_full));
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));
endmodule

bind adc_sequencer seq_checker #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .conv_req   (conv_req),
    .irq        (irq),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .busy       (busy),
    .ovf        (ovf),
    .trg_ovr    (trg_ovr),
    .fifo_full  (fifo_full),
    .fifo_count (fifo_count)
);

// File: tb/adc_sequencer_tb_top.sv
`timescale 1ns/1ps
// Directed bench for adc_sequencer with a behavioural converter model.
module adc_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        conv_req, conv_diff;
    logic [2:0]  conv_chan;
    logic        conv_done = 1'b0;
    logic [11:0] conv_result = '0;
    logic        irq;

    int errors = 0, checks = 0;
    int lat = 2;
    int log_n = 0, overlap = 0;
    logic [2:0] log_chan [64];
    logic       log_diff [64];
    logic       m_busy = 1'b0;
    int         m_wait = 0, m_idx = 0;
    logic [2:0] m_chan = '0;
    logic       m_diff = 1'b0;

    always #5 clk = ~clk;

    adc_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .trig(trig), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_diff(conv_diff),
        .conv_done(conv_done), .conv_result(conv_result), .irq(irq)
    );

    function automatic logic [11:0] mk_res(logic [2:0] c, logic d, int k);
        return (c == 3'd7) ? 12'hFFF : {c, d, 8'(k)};
    endfunction

    // Converter model: answers each request after lat cycles, logs requests.
    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_req) begin
            if (m_busy) overlap <= overlap + 1;
            m_busy <= 1'b1;
            m_wait <= lat;
            m_chan <= conv_chan;
            m_diff <= conv_diff;
            m_idx  <= log_n;
            log_chan[log_n] <= conv_chan;
            log_diff[log_n] <= conv_diff;
            log_n <= log_n + 1;
        end else if (m_busy) begin
            if (m_wait == 0) begin
                conv_done   <= 1'b1;
                conv_result <= mk_res(m_chan, m_diff, m_idx);
                m_busy      <= 1'b0;
            end else begin
                m_wait <= m_wait - 1;
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic fire();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 500; i++) begin
            rd(5'd0, s);
            if (!s[0]) break;
        end
    endtask

    function automatic logic [15:0] sw(int ch, int df, int ie, int last);
        return 16'((last << 5) | (ie << 4) | (df << 3) | ch);
    endfunction

    task automatic t_reset();
        logic [15:0] d;
        rd(5'd0, d);
        chk(d == 16'h0, "R1 status", d, 0);
        rd(5'd2, d);
        chk(d == 16'h4000, "R1 level", d, 16'h4000);
        chk(!irq && !conv_req, "R1 irq/req", {irq, conv_req}, 0);
        rd(5'd0, d);
        chk(d[0] == 1'b0, "R10 idle busy", d[0], 0);
    endtask

    task automatic t_basic();
        logic [15:0] d;
        int base;
        int ch[4] = '{3, 5, 0, 6};
        int df[4] = '{0, 1, 1, 0};
        for (int i = 0; i < 4; i++) wr(5'(16 + i), sw(ch[i], df[i], 0, i == 3));
        rd(5'd17, d);
        chk(d == sw(5, 1, 0, 0), "R2 step readback", d, sw(5, 1, 0, 0));
        base = log_n;
        fire();
        wait_idle();
        chk(log_n - base == 4, "R3 step count", log_n - base, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_chan[base + i] == 3'(ch[i]) && log_diff[base + i] == df[i][0],
                "R2 chan/diff", {log_chan[base + i], log_diff[base + i]}, {ch[i][2:0], df[i][0]});
        end
        chk(overlap == 0, "R2 request overlap", overlap, 0);
        rd(5'd2, d);
        chk(d == 16'h0004, "R6 level 4", d, 4);
        chk(irq == 1'b0, "R8 no irq", irq, 0);
        for (int i = 0; i < 4; i++) begin
            rd(5'd1, d);
            chk(d[11:0] == mk_res(log_chan[base + i], log_diff[base + i], base + i),
                "R5 data order", d, mk_res(log_chan[base + i], log_diff[base + i], base + i));
        end
        rd(5'd2, d);
        chk(d == 16'h4000, "R6 level empty", d, 16'h4000);
    endtask

    task automatic t_irq();
        logic [15:0] d;
        int base;
        wr(5'd16, sw(7, 0, 1, 1));
        base = log_n;
        fire();
        wait_idle();
        chk(log_n - base == 1, "R3 single step", log_n - base, 1);
        chk(irq == 1'b1, "R8 irq set", irq, 1);
        rd(5'd0, d);
        chk(d[1] == 1'b1, "R8 pending bit", d, 2);
        rd(5'd1, d);
        chk(d == 16'h0FFF, "R5 full scale", d, 16'h0FFF);
        wr(5'd0, 16'h000C);
        chk(irq == 1'b1, "R8 other-bit write", irq, 1);
        wr(5'd0, 16'h0002);
        chk(irq == 1'b0, "R8 cleared", irq, 0);
    endtask

    task automatic t_noend_and_ovf();
        logic [15:0] d;
        int base, base2;
        for (int i = 0; i < 8; i++) wr(5'(16 + i), sw(i, i % 2, 0, 0));
        base = log_n;
        fire();
        wait_idle();
        chk(log_n - base == 8, "R4 ran whole table", log_n - base, 8);
        for (int i = 0; i < 8; i++)
            chk(log_chan[base + i] == 3'(i), "R4 order", log_chan[base + i], i);
        rd(5'd2, d);
        chk(d == 16'h8008, "R6 level full", d, 16'h8008);
        wr(5'd17, sw(2, 0, 0, 1));
        base2 = log_n;
        fire();
        wait_idle();
        chk(log_n - base2 == 2, "R7 advances while full", log_n - base2, 2);
        rd(5'd0, d);
        chk(d[2] == 1'b1, "R7 overflow set", d, 4);
        rd(5'd2, d);
        chk(d == 16'h8008, "R7 level unchanged", d, 16'h8008);
        for (int i = 0; i < 8; i++) begin
            rd(5'd1, d);
            chk(d[11:0] == mk_res(log_chan[base + i], log_diff[base + i], base + i),
                "R7 kept data", d, mk_res(log_chan[base + i], log_diff[base + i], base + i));
        end
        wr(5'd0, 16'h0004);
        rd(5'd0, d);
        chk(d[2] == 1'b0, "R7 overflow cleared", d, 0);
    endtask

    task automatic t_overrun();
        logic [15:0] d;
        int base;
        lat = 20;
        wr(5'd16, sw(2, 0, 0, 0));
        wr(5'd17, sw(4, 1, 0, 1));
        base = log_n;
        fire();
        repeat (5) @(negedge clk);
        rd(5'd0, d);
        chk(d[0] == 1'b1, "R10 busy while running", d, 1);
        fire();
        wait_idle();
        chk(log_n - base == 2, "R9 extra trigger ignored", log_n - base, 2);
        rd(5'd0, d);
        chk(d == 16'h0008, "R9 overrun bit", d, 8);
        wr(5'd0, 16'h0008);
        rd(5'd0, d);
        chk(d == 16'h0000, "R9 overrun cleared", d, 0);
        rd(5'd2, d);
        chk(d == 16'h0002, "R5 two results", d, 2);
        lat = 2;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_irq();
        t_noend_and_ovf();
        t_overrun();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule